// File: doc/BRIEF.md
# Chained Device Addressing and Select Unit

This block gives each device on a shared command bus its own identity. It holds two registers of equal width (16 bits by default). The page register holds the address of this device. The select register holds the address that the bus master wants to talk to. The master first issues a target command that names one of the two registers. Each command-write that follows then loads the named register from the data bus.

The device counts as selected when the select value equals its own page value. The select value of all ones selects every device on the chain at once. In that broadcast state writes still land, but read-back is suppressed so that several devices never drive answers together. The page register refuses the all-ones value and flags the refused write.

A software reset returns the command sequencing to idle but keeps both addressing registers. Only the hard reset clears them.

Top module: `devsel_unit`

## Requirements
- R1: After hard reset (`rst_n` low) both registers read as zero, the target is none, `selected` and `rd_enable` are 1, and `pa_reject` and `rd_valid` are 0.
- R2: A `tgt_strobe` cycle latches the target from `tgt_code`: 2'b01 is the page register, 2'b10 is the select register, and 2'b00 or 2'b11 is none. The target persists until the next target strobe or a software reset.
- R3: A `wr_strobe` cycle with the select register targeted loads `wr_data` into it, whether or not the device is selected.
- R4: A `wr_strobe` cycle with the page register targeted loads `wr_data` only while `selected` is 1, broadcast included. Otherwise the write is ignored.
- R5: A page write of all ones leaves the page register unchanged. It raises `pa_reject` for exactly the one cycle after the write.
- R6: `selected` is 1 exactly when the select register equals the page register or holds all ones. It follows register changes with no extra delay.
- R7: `rd_enable` is 1 only when the select register equals the page register. Broadcast selection alone leaves it at 0.
- R8: An `rd_strobe` cycle with `rd_enable` at 1 gives `rd_valid` = 1 in the next cycle, with `rd_data` set to the targeted register, or zero when no register is targeted. With `rd_enable` at 0 no `rd_valid` follows.
- R9: `soft_rst` leaves both registers unchanged and clears the target to none. It overrides a target strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| soft_rst | input | 1 | Software reset, synchronous |
| tgt_strobe | input | 1 | Target command cycle |
| tgt_code | input | 2 | Register named by the target command |
| wr_strobe | input | 1 | Command-write cycle |
| wr_data | input | W | Command-write data |
| rd_strobe | input | 1 | Read request |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | W | Read data, zero when not valid |
| selected | output | 1 | Device addressed (direct or broadcast) |
| rd_enable | output | 1 | Device may answer reads |
| pa_reject | output | 1 | One-cycle pulse after a refused page write |

## Verification
The assertions assume that every strobe input is a clean level sampled at the rising edge. They also assume that `tgt_strobe` and `wr_strobe` are never both high in one cycle. The stimulus meets both by driving every input on the falling edge and by issuing target, write and read commands one per cycle through separate tasks. It releases hard reset only between commands.

// File: rtl/devsel_pkg.sv
package devsel_pkg;

  typedef enum logic [1:0] {
    TGT_NONE = 2'b00,
    TGT_PAGE = 2'b01,
    TGT_SEL  = 2'b10,
    TGT_RSVD = 2'b11
  } tgt_e;

  function automatic tgt_e decode_tgt(input logic [1:0] code);
    tgt_e t;
    case (code)
      2'b01:   t = TGT_PAGE;
      2'b10:   t = TGT_SEL;
      default: t = TGT_NONE;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/devsel_target.sv
module devsel_target
  import devsel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic tgt_strobe,
  input  logic [1:0] tgt_code,
  output tgt_e tgt_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tgt_q <= TGT_NONE;
    else if (soft_rst)   tgt_q <= TGT_NONE;
    else if (tgt_strobe) tgt_q <= decode_tgt(tgt_code);
  end

endmodule

// File: rtl/devsel_match.sv
module devsel_match #(
  parameter int W = 16
) (
  input  logic [W-1:0] pa_q,
  input  logic [W-1:0] ds_q,
  output logic         bcast,
  output logic         direct,
  output logic         selected,
  output logic         rd_enable
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  function automatic logic is_all_ones(input logic [W-1:0] v);
    return v == ALL_ONES;
  endfunction

  always_comb begin
    bcast     = is_all_ones(ds_q);
    direct    = (ds_q == pa_q);
    selected  = bcast | direct;
    rd_enable = direct;
  end

endmodule

// File: rtl/devsel_regs.sv
module devsel_regs
  import devsel_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  tgt_e         tgt_q,
  input  logic         wr_strobe,
  input  logic [W-1:0] wr_data,
  input  logic         selected,
  output logic [W-1:0] pa_q,
  output logic [W-1:0] ds_q,
  output logic         pa_load,
  output logic         ds_load,
  output logic         pa_bad_wr,
  output logic         pa_reject
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic pa_wr_req;

  always_comb begin
    pa_wr_req = wr_strobe && (tgt_q == TGT_PAGE) && selected;
    pa_bad_wr = pa_wr_req && (wr_data == ALL_ONES);
    pa_load   = pa_wr_req && !pa_bad_wr;
    ds_load   = wr_strobe && (tgt_q == TGT_SEL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q      <= '0;
      ds_q      <= '0;
      pa_reject <= 1'b0;
    end else begin
      if (pa_load) pa_q <= wr_data;
      if (ds_load) ds_q <= wr_data;
      pa_reject <= pa_bad_wr;
    end
  end

endmodule

// File: rtl/devsel_readout.sv
module devsel_readout
  import devsel_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_strobe,
  input  logic         rd_enable,
  input  tgt_e         tgt_q,
  input  logic [W-1:0] pa_q,
  input  logic [W-1:0] ds_q,
  output logic         rd_fire,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);

  logic [W-1:0] mux_val;

  always_comb begin
    rd_fire = rd_strobe && rd_enable;
    case (tgt_q)
      TGT_PAGE: mux_val = pa_q;
      TGT_SEL:  mux_val = ds_q;
      default:  mux_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_fire;
      rd_data  <= rd_fire ? mux_val : '0;
    end
  end

endmodule

// File: rtl/devsel_unit.sv
module devsel_unit
  import devsel_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic         tgt_strobe,
  input  logic [1:0]   tgt_code,
  input  logic         wr_strobe,
  input  logic [W-1:0] wr_data,
  input  logic         rd_strobe,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic         selected,
  output logic         rd_enable,
  output logic         pa_reject
);

  tgt_e         tgt_q;
  logic [W-1:0] pa_q;
  logic [W-1:0] ds_q;
  logic         bcast;
  logic         direct;
  logic         pa_load;
  logic         ds_load;
  logic         pa_bad_wr;
  logic         rd_fire;

  devsel_target u_target (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .tgt_strobe (tgt_strobe),
    .tgt_code   (tgt_code),
    .tgt_q      (tgt_q)
  );

  devsel_match #(.W(W)) u_match (
    .pa_q      (pa_q),
    .ds_q      (ds_q),
    .bcast     (bcast),
    .direct    (direct),
    .selected  (selected),
    .rd_enable (rd_enable)
  );

  devsel_regs #(.W(W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .tgt_q     (tgt_q),
    .wr_strobe (wr_strobe),
    .wr_data   (wr_data),
    .selected  (selected),
    .pa_q      (pa_q),
    .ds_q      (ds_q),
    .pa_load   (pa_load),
    .ds_load   (ds_load),
    .pa_bad_wr (pa_bad_wr),
    .pa_reject (pa_reject)
  );

  devsel_readout #(.W(W)) u_readout (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_strobe (rd_strobe),
    .rd_enable (rd_enable),
    .tgt_q     (tgt_q),
    .pa_q      (pa_q),
    .ds_q      (ds_q),
    .rd_fire   (rd_fire),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/devsel_unit_chk.sv
module devsel_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         soft_rst,
  input logic         wr_strobe,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] pa_q,
  input logic [W-1:0] ds_q,
  input logic         pa_bad_wr,
  input logic         ds_load,
  input logic         selected,
  input logic         rd_enable,
  input logic         rd_fire,
  input logic         rd_valid,
  input logic         pa_reject
);

  localparam logic [W-1:0] ONES = {W{1'b1}};

  // R5: a refused page write keeps the old value and raises the flag next cycle
  a_r5_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    pa_bad_wr |=> pa_reject && $stable(pa_q));

  // R5: the flag only follows a write cycle
  a_r5_reject_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    pa_reject |-> $past(wr_strobe));

  // R3: a select write lands the bus value
  a_r3_sel_loads: assert property (@(posedge clk) disable iff (!rst_n)
    ds_load |=> ds_q == $past(wr_data));

  // R9: software reset without a write keeps both registers
  a_r9_soft_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !wr_strobe) |=> $stable(pa_q) && $stable(ds_q));

  // R7: broadcast alone never enables reads
  a_r7_bcast_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_q == ONES) |-> !rd_enable);

  // R6: equal registers mean addressed and readable
  a_r6_direct_select: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_q == pa_q) |-> selected && rd_enable);

  // R8: a valid answer always stems from an enabled request
  a_r8_valid_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_fire));

  // R5: the page register never holds all ones
  a_r5_page_never_ones: assert property (@(posedge clk) disable iff (!rst_n)
    pa_q != ONES);

endmodule

bind devsel_unit devsel_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .soft_rst  (soft_rst),
  .wr_strobe (wr_strobe),
  .wr_data   (wr_data),
  .pa_q      (pa_q),
  .ds_q      (ds_q),
  .pa_bad_wr (pa_bad_wr),
  .ds_load   (ds_load),
  .selected  (selected),
  .rd_enable (rd_enable),
  .rd_fire   (rd_fire),
  .rd_valid  (rd_valid),
  .pa_reject (pa_reject)
);

// File: tb/devsel_unit_bench.sv
`timescale 1ns/1ps
module devsel_unit_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         soft_rst = 1'b0;
  logic         tgt_strobe = 1'b0;
  logic [1:0]   tgt_code = 2'b00;
  logic         wr_strobe = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         rd_strobe = 1'b0;
  logic         rd_valid;
  logic [W-1:0] rd_data;
  logic         selected;
  logic         rd_enable;
  logic         pa_reject;

  int n_cmp = 0;
  int n_bad = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  devsel_unit #(.W(W)) u_devsel_unit (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .tgt_strobe(tgt_strobe), .tgt_code(tgt_code),
    .wr_strobe(wr_strobe), .wr_data(wr_data),
    .rd_strobe(rd_strobe), .rd_valid(rd_valid), .rd_data(rd_data),
    .selected(selected), .rd_enable(rd_enable), .pa_reject(pa_reject)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_tgt(input logic [1:0] c);
    @(negedge clk); tgt_strobe = 1'b1; tgt_code = c;
    @(negedge clk); tgt_strobe = 1'b0;
  endtask

  task automatic do_wr(input logic [W-1:0] d);
    @(negedge clk); wr_strobe = 1'b1; wr_data = d;
    @(negedge clk); wr_strobe = 1'b0;
  endtask

  // expv=1: push expected data to scoreboard; expv=0: no answer allowed
  task automatic do_rd(input bit expv, input logic [W-1:0] e, input string tag);
    @(negedge clk); rd_strobe = 1'b1;
    if (expv) begin exp_q.push_back(e); tag_q.push_back(tag); end
    @(negedge clk); rd_strobe = 1'b0;
    if (!expv) chk(rd_valid == 1'b0, tag, int'(rd_valid), 0);
  endtask

  task automatic chk_sel(input bit s, input bit r, input string tag);
    chk(selected == s, tag, int'(selected), int'(s));
    chk(rd_enable == r, tag, int'(rd_enable), int'(r));
  endtask

  // monitor: pops the scoreboard on each answer
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected answer", int'(rd_data), 0);
      end else begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rd_data == e, t, int'(rd_data), int'(e));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_sel(1'b1, 1'b1, "R1 reset select");
    chk(pa_reject == 1'b0, "R1 reset reject", int'(pa_reject), 0);
    chk(rd_valid == 1'b0, "R1 reset valid", int'(rd_valid), 0);
    do_rd(1'b1, 16'h0000, "R2 none target reads zero");
    do_tgt(2'b01); do_rd(1'b1, 16'h0000, "R1 page zero after reset");
    do_tgt(2'b10); do_rd(1'b1, 16'h0000, "R1 select zero after reset");

    // R4 page write while selected
    do_tgt(2'b01); do_wr(16'h0005);
    chk_sel(1'b0, 1'b0, "R6 mismatch deselects");
    do_rd(1'b0, 16'h0, "R8 no answer when disabled");
    do_wr(16'h0007); // ignored: not selected
    do_tgt(2'b10); do_wr(16'h0005); // R3 select write while unselected
    chk_sel(1'b1, 1'b1, "R3 select write lands");
    do_rd(1'b1, 16'h0005, "R3 select readback");
    do_tgt(2'b01); do_rd(1'b1, 16'h0005, "R4 unselected page write ignored");

    // R5 reject
    do_wr(16'hFFFF);
    chk(pa_reject == 1'b1, "R5 reject pulse", int'(pa_reject), 1);
    @(negedge clk);
    chk(pa_reject == 1'b0, "R5 reject one cycle", int'(pa_reject), 0);
    do_rd(1'b1, 16'h0005, "R5 page kept");

    // broadcast
    do_tgt(2'b10); do_wr(16'hFFFF);
    chk_sel(1'b1, 1'b0, "R7 broadcast blocks read");
    do_rd(1'b0, 16'h0, "R7 no answer in broadcast");
    do_tgt(2'b01); do_wr(16'h0009);
    chk(pa_reject == 1'b0, "R4 broadcast page write no reject", int'(pa_reject), 0);
    do_tgt(2'b10); do_wr(16'h0009);
    chk_sel(1'b1, 1'b1, "R6 direct after broadcast");
    do_tgt(2'b01); do_rd(1'b1, 16'h0009, "R4 page write under broadcast");

    // R9 soft reset
    @(negedge clk); soft_rst = 1'b1; tgt_strobe = 1'b1; tgt_code = 2'b10;
    @(negedge clk); soft_rst = 1'b0; tgt_strobe = 1'b0;
    chk_sel(1'b1, 1'b1, "R9 select kept");
    do_rd(1'b1, 16'h0000, "R9 target cleared");
    do_tgt(2'b01); do_rd(1'b1, 16'h0009, "R9 page kept");
    do_tgt(2'b10); do_rd(1'b1, 16'h0009, "R9 select kept readback");

    // R2 reserved code
    do_tgt(2'b11); do_rd(1'b1, 16'h0000, "R2 reserved code is none");
    do_wr(16'h0033);
    chk_sel(1'b1, 1'b1, "R2 write to none is dropped");

    // R1 hard reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    do_tgt(2'b01); do_rd(1'b1, 16'h0000, "R1 page cleared");
    do_tgt(2'b10); do_rd(1'b1, 16'h0000, "R1 select cleared");
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R8 answers missing", exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule